// File: doc/BRIEF.md
# Fixed-Level Interrupt Request Handshake Controller

This block converts an interrupt request raised by a bus-side function at one fixed priority level into a CPU interrupt. When the request line goes low, the block tells the CPU that a request is waiting. When the CPU signals that it can take the interrupt, the block latches the request. After a fixed settling delay it selects the requesting function and sends a one-cycle precedence pulse with the select.

The function answers with its acknowledge. The bus timing unit then returns an acknowledge strobe, and that strobe loads the interrupt level register. The register drives a two-bit level code and an active-low interrupt flag to the CPU. Loading the register drops the select and clears the request latch. The CPU later issues a clear, which empties the level register. The block takes a new request only after it has seen that clear and the request line has gone high again.

The settling delay is a number of clock cycles. It is derived from the clock period and the wanted delay in picoseconds, rounded up, and is never less than one cycle. With the default 4 ns clock and 20 ns delay it is five cycles.

Top module: `irqh_ctrl`

## Requirements
- R1: While reset is applied and right after it, pend_n=1, sel_n=1, prec=0, lvl_code=2'b00 and irq_n=1.
- R2: When the block is idle and re-armed, a low req_n sampled on a clock edge drives pend_n low from that edge. pend_n stays low until cpu_rdy_n is sampled low or the request is withdrawn.
- R3: If req_n is sampled high while pend_n is low, pend_n returns high on that edge and no select follows. A withdrawal takes priority over a ready seen in the same cycle.
- R4: cpu_rdy_n sampled low while pend_n is low drives pend_n high on that edge. sel_n then goes low exactly DLY further edges later, where DLY = max(1, ceil(SEL_DELAY_PS / CLK_PERIOD_PS)). The default is 5, so sel_n is low from the 6th edge counted from the ready edge.
- R5: prec is high for exactly one cycle, and that cycle is the first one in which sel_n is low.
- R6: While sel_n is low, tmg_ack is honoured only if fn_ack_n is low in the same cycle or was sampled low earlier in this selection. Otherwise tmg_ack is ignored and sel_n stays low.
- R7: An honoured tmg_ack drives sel_n high on the same edge, sets lvl_code to 2'b11 (level four) and sets irq_n low.
- R8: cpu_clr_n sampled low sets lvl_code to 2'b00 and irq_n high on that edge. The clear wins over a load in the same cycle.
- R9: After a load, a low req_n is ignored and pend_n stays high until cpu_clr_n has been sampled low and req_n has then been sampled high.
- R10: A low cpu_rdy_n while pend_n is high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Interrupt request from the bus function, active low |
| cpu_rdy_n | input | 1 | CPU ready to accept the interrupt, active low |
| fn_ack_n | input | 1 | Acknowledge from the selected function, active low |
| tmg_ack | input | 1 | Acknowledge strobe from the bus timing unit |
| cpu_clr_n | input | 1 | CPU clear of the level register, active low |
| pend_n | output | 1 | Request pending indication to the CPU, active low |
| sel_n | output | 1 | Level select to the requesting function, active low |
| prec | output | 1 | Precedence pulse sent with the select |
| lvl_code | output | 2 | Binary interrupt level code to the CPU |
| irq_n | output | 1 | Interrupt to the CPU, active low |

## Verification
A miscounted delay counter moves the falling edge of sel_n and the prec pulse away from edge DLY+1 after the ready edge, and the per-clock comparison catches that in the cycle it happens. A lost acknowledge flag has two possible effects. It can make a lone timing strobe load the register, or it can make an honoured strobe be ignored. Either shows up in the next cycle on irq_n and sel_n. A wrong re-arm flag shows up as pend_n falling while irq_n is still low, or as pend_n staying high after the clear and release. That difference appears on the first edge after the req_n stimulus.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_DELAY = 3'd2,
        ST_SEL   = 3'd3,
        ST_HOLD  = 3'd4
    } irqh_state_e;

    function automatic int unsigned sel_delay_cycles(input int unsigned delay_ps,
                                                     input int unsigned period_ps);
        int unsigned c;
        c = (delay_ps + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/irqh_sel_delay.sv
module irqh_sel_delay #(
    parameter int unsigned DLY_CYC = 5,
    localparam int unsigned CNT_W  = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(DLY_CYC - 1);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/irqh_level_reg.sv
module irqh_level_reg #(
    parameter int unsigned    LVL_W    = 2,
    parameter logic [LVL_W-1:0] LVL_CODE = 2'b11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr_n,
    output logic [LVL_W-1:0] code,
    output logic             irq_n
);

    typedef struct packed {
        logic [LVL_W-1:0] code;
        logic             act;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (!clr_n) begin
            lvl_d.code = '0;
            lvl_d.act  = 1'b0;
        end else if (load) begin
            lvl_d.code = LVL_CODE;
            lvl_d.act  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign code  = lvl_q.code;
    assign irq_n = !lvl_q.act;

endmodule

// File: rtl/irqh_ctrl.sv
module irqh_ctrl #(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned SEL_DELAY_PS  = 20000,
    parameter int unsigned LVL_W         = 2,
    parameter logic [LVL_W-1:0] LVL_CODE = 2'b11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             cpu_rdy_n,
    input  logic             fn_ack_n,
    input  logic             tmg_ack,
    input  logic             cpu_clr_n,
    output logic             pend_n,
    output logic             sel_n,
    output logic             prec,
    output logic [LVL_W-1:0] lvl_code,
    output logic             irq_n
);
    import irqh_pkg::*;

    localparam int unsigned DLY_CYC = sel_delay_cycles(SEL_DELAY_PS, CLK_PERIOD_PS);

    typedef struct packed {
        irqh_state_e st;
        logic        lat;
        logic        ack;
        logic        clr_seen;
        logic        prec;
    } ctl_t;

    ctl_t c_d, c_q;
    logic dly_load, dly_exp, lvl_load, ack_ok, clr_ok;

    irqh_sel_delay #(.DLY_CYC(DLY_CYC)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .run     (c_q.st == ST_DELAY),
        .expired (dly_exp)
    );

    irqh_level_reg #(.LVL_W(LVL_W), .LVL_CODE(LVL_CODE)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lvl_load),
        .clr_n (cpu_clr_n),
        .code  (lvl_code),
        .irq_n (irq_n)
    );

    assign ack_ok = c_q.ack || !fn_ack_n;
    assign clr_ok = c_q.clr_seen || !cpu_clr_n;

    always_comb begin
        c_d      = c_q;
        c_d.prec = 1'b0;
        dly_load = 1'b0;
        lvl_load = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (!req_n) c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (req_n) begin
                    c_d.st = ST_IDLE;
                end else if (!cpu_rdy_n) begin
                    c_d.st   = ST_DELAY;
                    c_d.lat  = 1'b1;
                    dly_load = 1'b1;
                end
            end
            ST_DELAY: begin
                if (dly_exp) begin
                    c_d.st   = ST_SEL;
                    c_d.prec = 1'b1;
                    c_d.ack  = 1'b0;
                end
            end
            ST_SEL: begin
                if (tmg_ack && ack_ok) begin
                    c_d.st       = ST_HOLD;
                    c_d.lat      = 1'b0;
                    c_d.ack      = 1'b0;
                    c_d.clr_seen = !cpu_clr_n;
                    lvl_load     = 1'b1;
                end else if (!fn_ack_n) begin
                    c_d.ack = 1'b1;
                end
            end
            ST_HOLD: begin
                if (clr_ok && req_n) begin
                    c_d.st       = ST_IDLE;
                    c_d.clr_seen = 1'b0;
                end else begin
                    c_d.clr_seen = clr_ok;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st       <= ST_IDLE;
            c_q.lat      <= 1'b0;
            c_q.ack      <= 1'b0;
            c_q.clr_seen <= 1'b0;
            c_q.prec     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pend_n = (c_q.st != ST_WAIT);
    assign sel_n  = !((c_q.st == ST_SEL) && c_q.lat);
    assign prec   = c_q.prec;

endmodule

// File: rtl/irqh_ctrl_chk.sv
module irqh_ctrl_chk #(
    parameter int unsigned LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_clr_n,
    input logic             tmg_ack,
    input logic             pend_n,
    input logic             sel_n,
    input logic             prec,
    input logic [LVL_W-1:0] lvl_code,
    input logic             irq_n
);

    // R5
    prec_with_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prec |-> !sel_n);

    // R5
    prec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prec |=> !prec);

    // R5
    sel_fall_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> prec);

    // R2
    pend_sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_n |-> sel_n);

    // R7
    load_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> (lvl_code == 2'b11) && sel_n && $past(tmg_ack));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clr_n |=> irq_n && (lvl_code == '0));

    // R9
    no_pend_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> pend_n);

endmodule

bind irqh_ctrl irqh_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_clr_n (cpu_clr_n),
    .tmg_ack   (tmg_ack),
    .pend_n    (pend_n),
    .sel_n     (sel_n),
    .prec      (prec),
    .lvl_code  (lvl_code),
    .irq_n     (irq_n)
);

// File: tb/test_irqh_ctrl.sv
module test_irqh_ctrl;

    localparam int DLY = (20000 + 4000 - 1) / 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1, cpu_rdy_n = 1'b1, fn_ack_n = 1'b1, tmg_ack = 1'b0, cpu_clr_n = 1'b1;
    logic pend_n, sel_n, prec, irq_n;
    logic [1:0] lvl_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irqh_ctrl i_irqh_ctrl (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .cpu_rdy_n(cpu_rdy_n),
        .fn_ack_n(fn_ack_n), .tmg_ack(tmg_ack), .cpu_clr_n(cpu_clr_n),
        .pend_n(pend_n), .sel_n(sel_n), .prec(prec), .lvl_code(lvl_code), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: phase 0 idle, 1 pending, 2 delaying, 3 selected, 4 holding
    int  m_ph = 0, m_cnt = 0;
    bit  m_ack = 0, m_clr = 0, m_prec = 0, m_irq = 0;
    int  m_code = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_ack = 0; m_clr = 0; m_prec = 0; m_irq = 0; m_code = 0;
        end else begin
            bit load;
            load = 0;
            m_prec = 0;
            case (m_ph)
                0: if (!req_n) m_ph = 1;
                1: if (req_n) m_ph = 0;
                   else if (!cpu_rdy_n) begin m_ph = 2; m_cnt = DLY - 1; end
                2: if (m_cnt == 0) begin m_ph = 3; m_prec = 1; m_ack = 0; end
                   else m_cnt--;
                3: if (tmg_ack && (m_ack || !fn_ack_n)) begin
                       m_ph = 4; load = 1; m_ack = 0; m_clr = !cpu_clr_n;
                   end else if (!fn_ack_n) m_ack = 1;
                default: begin
                    if ((m_clr || !cpu_clr_n) && req_n) begin m_ph = 0; m_clr = 0; end
                    else m_clr = m_clr || !cpu_clr_n;
                end
            endcase
            if (!cpu_clr_n) begin m_code = 0; m_irq = 0; end
            else if (load)  begin m_code = 3; m_irq = 1; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pend_n == (m_ph != 1), "R2 pend_n", pend_n, m_ph != 1);
            chk(sel_n == (m_ph != 3), "R4 sel_n", sel_n, m_ph != 3);
            chk(prec == m_prec, "R5 prec", prec, m_prec);
            chk(lvl_code == m_code, "R7 lvl_code", lvl_code, m_code);
            chk(irq_n == !m_irq, "R8 irq_n", irq_n, !m_irq);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_select();
        int n;
        req_n = 0;
        tick(1);
        cpu_rdy_n = 0;
        n = 0;
        tick(1); n++;
        cpu_rdy_n = 1;
        while (sel_n && n < 50) begin tick(1); n++; end
        chk(n == DLY + 1, "R4 select delay", n, DLY + 1);
        chk(prec == 1'b1, "R5 prec on first select cycle", prec, 1);
    endtask

    initial begin
        tick(1);
        chk(pend_n && sel_n && !prec && lvl_code == 0 && irq_n, "R1 during reset",
            {pend_n, sel_n, prec, irq_n}, 4'b1101);
        tick(2);
        rst_n = 1;
        tick(1);
        chk(pend_n && sel_n && !prec && lvl_code == 0 && irq_n, "R1 after reset",
            {pend_n, sel_n, prec, irq_n}, 4'b1101);

        // R10: ready with nothing pending
        cpu_rdy_n = 0; tick(3); cpu_rdy_n = 1; tick(1);
        chk(pend_n && sel_n, "R10 stray ready", {pend_n, sel_n}, 2'b11);

        // R2 and R3: pending then withdrawn
        req_n = 0; tick(1);
        chk(!pend_n, "R2 pending shown", pend_n, 0);
        tick(3);
        chk(!pend_n, "R2 pending held", pend_n, 0);
        req_n = 1; cpu_rdy_n = 0; tick(1); cpu_rdy_n = 1;
        chk(pend_n, "R3 withdraw wins", pend_n, 1);
        tick(DLY + 3);
        chk(sel_n, "R3 no select after withdraw", sel_n, 1);

        // R4..R7 normal flow, R6 lone timing strobe ignored
        go_select();
        tick(1);
        chk(!prec && !sel_n, "R5 prec one cycle", prec, 0);
        tmg_ack = 1; tick(1); tmg_ack = 0;
        chk(!sel_n && irq_n, "R6 strobe without ack ignored", sel_n, 0);
        fn_ack_n = 0; tick(2); fn_ack_n = 1; tick(1);
        chk(!sel_n, "R6 ack alone keeps select", sel_n, 0);
        tmg_ack = 1; tick(1); tmg_ack = 0;
        chk(sel_n && irq_n == 0 && lvl_code == 2'b11, "R7 level loaded",
            {sel_n, irq_n, lvl_code}, 4'b1011);

        // R9: request ignored until clear and release
        tick(3);
        chk(pend_n, "R9 request ignored while active", pend_n, 1);
        cpu_clr_n = 0; tick(1); cpu_clr_n = 1;
        chk(irq_n && lvl_code == 0, "R8 cleared", {irq_n, lvl_code}, 3'b100);
        tick(3);
        chk(pend_n, "R9 ignored until release", pend_n, 1);
        req_n = 1; tick(1);
        req_n = 0; tick(1);
        chk(!pend_n, "R9 re-armed", pend_n, 0);
        req_n = 1; tick(2);

        // R8: clear clashing with load, same-cycle ack
        go_select();
        fn_ack_n = 0; tmg_ack = 1; cpu_clr_n = 0; tick(1);
        fn_ack_n = 1; tmg_ack = 0; cpu_clr_n = 1;
        chk(sel_n && irq_n && lvl_code == 0, "R8 clear beats load",
            {sel_n, irq_n, lvl_code}, 4'b1100);
        tick(2);
        req_n = 1; tick(1);
        req_n = 0; tick(1);
        chk(!pend_n, "R9 re-armed after clear at load", pend_n, 0);
        req_n = 1; tick(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        done = 1;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule